// File: doc/BRIEF.md
# Dual-Slot Instruction Word Dispatcher

This block sits between instruction fetch and the execute units of a two-slot processor. It takes one fetched 32-bit word at a time and decides how to run it. The two top bits select the format. The word holds either one 30-bit long operation or two 15-bit short operations, called the left slot and the right slot. Short operations run one after the other in a fixed order, or as a parallel pair in which a condition-test operation can guard its partner.

Each operation goes out on one issue port, together with its payload, its slot tag and its opcode class. The issue is held until the execute side returns a one-cycle acknowledge. That acknowledge carries three feedback bits: the PC changed, an exception was raised, or the condition test was true. The dispatcher uses this feedback to decide whether the second slot runs. When the word is finished it pulses `done`, and at the same time it pulses at most one outcome event.

Top module: `wd_dispatch`

## Requirements
- R1: After a synchronous active-low reset, `issue_valid`, `issue_test`, `done` and all three event outputs are 0.
- R2: Format bits 31:30 = 11 give a long word. It produces exactly one issue with tag 00, payload bits 29:0 and class bits 29:24. `done` follows in the cycle after its acknowledge.
- R3: Format 01 is serial left-first. The left slot (bits 29:15, tag 01) is issued first and then the right slot (bits 14:0, tag 10). Short payloads are zero-extended to 30 bits.
- R4: Format 10 is serial right-first. The right slot is issued first and then the left slot.
- R5: In serial formats, the second slot is not issued if the first slot's acknowledge reports a PC change or an exception. `ev_branch_skip` pulses with `done` exactly when the PC changed and no exception was raised.
- R6: In format 00, a short slot is a condition test when (class & COND_MASK) == (COND_CLASS & COND_MASK). With the defaults 3A/3E, this means classes 3A and 3B. If one slot is a condition test, it is issued first with `issue_test` high, and the left slot wins if both slots are tests. Its partner is issued only if `exec_cond` is 1 at the test's acknowledge. `ev_cond_true` or `ev_cond_false` pulses with `done` to report the result.
- R7: In format 00 without a condition-test slot, the left slot is issued and then the right slot. The right slot is dropped if the left slot's acknowledge reports an exception. A PC change has no effect in this case.
- R8: The class of a short slot is bits 14:9 of that slot.
- R9: An issue stays valid with a stable payload and tag until the acknowledge. The next slot is issued in the cycle after the acknowledge. `done` is a single-cycle pulse, one cycle after the last acknowledge, and is never high while an issue is valid.
- R10: `word_valid` is ignored while a word is in progress. No extra issue results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | Fetched word present; taken only when idle |
| word_in | input | 32 | Fetched instruction word |
| exec_ack | input | 1 | Execute-complete acknowledge for the current issue |
| exec_pc_chg | input | 1 | Issued operation changed the PC (valid with ack) |
| exec_exc | input | 1 | Issued operation raised an exception (valid with ack) |
| exec_cond | input | 1 | Condition-test result (valid with ack) |
| issue_valid | output | 1 | An operation is being issued |
| issue_tag | output | 2 | 00 long, 01 left slot, 10 right slot |
| issue_payload | output | 30 | Operation bits, short slots zero-extended |
| issue_class | output | 6 | Opcode class used for lookup |
| issue_test | output | 1 | Current issue is the guarding condition test |
| done | output | 1 | Word finished (one-cycle pulse) |
| ev_cond_true | output | 1 | Guarded partner was executed |
| ev_cond_false | output | 1 | Guarded partner was skipped |
| ev_branch_skip | output | 1 | Serial second slot skipped because of a PC change |

## Verification
The hardest case to reach is feedback that arrives with the first acknowledge and changes what happens next. Examples are a PC change together with an exception in a serial word, a PC change in a parallel word (where it must be ignored), and a pair whose two slots both decode as condition tests. The bench drives the feedback bits only on the first acknowledge of each word and varies the acknowledge delay from zero to several cycles. It also places a second word strobe in the middle of a word. The scoreboard then shows whether a slot was skipped, reordered or added.

// File: rtl/wd_pkg.sv
// Package: shared encodings for the dual-slot dispatcher.
package wd_pkg;
    // Slot tag seen by the execute units.
    typedef enum logic [1:0] {
        TAG_LONG  = 2'b00,
        TAG_LEFT  = 2'b01,
        TAG_RIGHT = 2'b10
    } slot_tag_e;

    // How the two slots of a word relate.
    typedef enum logic [1:0] {
        M_LONG,    // one long operation
        M_SERIAL,  // ordered pair, second dropped on branch/exception
        M_PRED,    // parallel pair guarded by a condition test
        M_PAR      // parallel pair, second dropped on exception
    } mode_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FIRST,
        S_SECOND,
        S_FIN
    } state_e;

    // Format field values (bits 31:30 of the word).
    localparam logic [1:0] FMT_PAR  = 2'b00;
    localparam logic [1:0] FMT_LR   = 2'b01;
    localparam logic [1:0] FMT_RL   = 2'b10;
    localparam logic [1:0] FMT_LONG = 2'b11;
endpackage

// File: rtl/wd_decode.sv
// Module: wd_decode
// Classifies a held instruction word into an issue mode and the order of
// its slots. Purely combinational; assumes the word is stable while busy.
module wd_decode
    import wd_pkg::*;
#(
    parameter int SLOT_W = 15,
    parameter int CLS_W  = 6,
    parameter logic [CLS_W-1:0] COND_CLASS = 6'h3A,
    parameter logic [CLS_W-1:0] COND_MASK  = 6'h3E,
    localparam int WORD_W = 2 * SLOT_W + 2
) (
    input  logic [WORD_W-1:0] word,
    output mode_e             mode,
    output slot_tag_e         first_tag,
    output slot_tag_e         second_tag
);
    // Index 1 is the left slot, index 0 the right slot.
    logic [1:0] is_test;

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_slot
            logic [SLOT_W-1:0] slot;
            logic [CLS_W-1:0]  cls;
            // Extract one short slot and test its class against the guard class.
            assign slot       = word[g*SLOT_W +: SLOT_W];
            assign cls        = slot[SLOT_W-1 -: CLS_W];
            assign is_test[g] = ((cls & COND_MASK) == (COND_CLASS & COND_MASK));
        end
    endgenerate

    // Select mode and slot order from the format field and the test flags.
    always_comb begin
        mode       = M_LONG;
        first_tag  = TAG_LONG;
        second_tag = TAG_LONG;
        unique case (word[WORD_W-1 -: 2])
            FMT_LONG: begin
                mode       = M_LONG;
                first_tag  = TAG_LONG;
                second_tag = TAG_LONG;
            end
            FMT_LR: begin
                mode       = M_SERIAL;
                first_tag  = TAG_LEFT;
                second_tag = TAG_RIGHT;
            end
            FMT_RL: begin
                mode       = M_SERIAL;
                first_tag  = TAG_RIGHT;
                second_tag = TAG_LEFT;
            end
            default: begin
                if (is_test[1]) begin
                    mode       = M_PRED;
                    first_tag  = TAG_LEFT;
                    second_tag = TAG_RIGHT;
                end else if (is_test[0]) begin
                    mode       = M_PRED;
                    first_tag  = TAG_RIGHT;
                    second_tag = TAG_LEFT;
                end else begin
                    mode       = M_PAR;
                    first_tag  = TAG_LEFT;
                    second_tag = TAG_RIGHT;
                end
            end
        endcase
    end
endmodule

// File: rtl/wd_select.sv
// Module: wd_select
// Picks the payload and opcode class of the slot named by a tag.
// Short payloads are zero-extended to the long width.
module wd_select
    import wd_pkg::*;
#(
    parameter int SLOT_W = 15,
    parameter int CLS_W  = 6,
    localparam int WORD_W = 2 * SLOT_W + 2,
    localparam int LONG_W = 2 * SLOT_W
) (
    input  logic [WORD_W-1:0] word,
    input  slot_tag_e         tag,
    output logic [LONG_W-1:0] payload,
    output logic [CLS_W-1:0]  cls
);
    logic [SLOT_W-1:0] left_s;
    logic [SLOT_W-1:0] right_s;

    assign left_s  = word[LONG_W-1:SLOT_W];
    assign right_s = word[SLOT_W-1:0];

    // Route the selected slot to the issue port.
    always_comb begin
        unique case (tag)
            TAG_LEFT: begin
                payload = {{SLOT_W{1'b0}}, left_s};
                cls     = left_s[SLOT_W-1 -: CLS_W];
            end
            TAG_RIGHT: begin
                payload = {{SLOT_W{1'b0}}, right_s};
                cls     = right_s[SLOT_W-1 -: CLS_W];
            end
            default: begin
                payload = word[LONG_W-1:0];
                cls     = word[LONG_W-1 -: CLS_W];
            end
        endcase
    end
endmodule

// File: rtl/wd_seq.sv
// Module: wd_seq
// Issue sequencer: takes a word when idle, issues the first slot, decides
// from the acknowledge feedback whether the second slot runs, then pulses
// done with the outcome events. Assumes feedback is valid only with ack.
module wd_seq
    import wd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      word_valid,
    input  logic      exec_ack,
    input  logic      exec_pc_chg,
    input  logic      exec_exc,
    input  logic      exec_cond,
    input  mode_e     mode,
    input  slot_tag_e first_tag,
    input  slot_tag_e second_tag,
    output logic      load,
    output logic      issue_valid,
    output slot_tag_e cur_tag,
    output logic      issue_test,
    output logic      done,
    output logic [2:0] events    // {branch_skip, cond_false, cond_true}
);
    state_e     state;
    logic [2:0] ev_q;
    logic       go_on;
    logic [2:0] ev_d;

    // Decide from first-slot feedback whether the second slot runs.
    always_comb begin
        go_on = 1'b0;
        ev_d  = 3'b000;
        unique case (mode)
            M_SERIAL: begin
                go_on   = !exec_pc_chg && !exec_exc;
                ev_d[2] = exec_pc_chg && !exec_exc;
            end
            M_PRED: begin
                go_on   = exec_cond;
                ev_d[0] = exec_cond;
                ev_d[1] = !exec_cond;
            end
            M_PAR:   go_on = !exec_exc;
            default: go_on = 1'b0;
        endcase
    end

    // State and outcome register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            ev_q  <= 3'b000;
        end else begin
            unique case (state)
                S_IDLE: if (word_valid) state <= S_FIRST;
                S_FIRST: begin
                    if (exec_ack) begin
                        state <= go_on ? S_SECOND : S_FIN;
                        ev_q  <= ev_d;
                    end
                end
                S_SECOND: if (exec_ack) state <= S_FIN;
                default: begin
                    state <= S_IDLE;
                    ev_q  <= 3'b000;
                end
            endcase
        end
    end

    assign load        = (state == S_IDLE) && word_valid;
    assign issue_valid = (state == S_FIRST) || (state == S_SECOND);
    assign cur_tag     = (state == S_SECOND) ? second_tag : first_tag;
    assign issue_test  = (state == S_FIRST) && (mode == M_PRED);
    assign done        = (state == S_FIN);
    assign events      = done ? ev_q : 3'b000;
endmodule

// File: rtl/wd_dispatch.sv
// Module: wd_dispatch (top)
// Dual-slot instruction word dispatcher. Holds the accepted word, decodes
// its format, and issues its slots in order with feedback-driven skipping.
module wd_dispatch
    import wd_pkg::*;
#(
    parameter int SLOT_W = 15,
    parameter int CLS_W  = 6,
    parameter logic [CLS_W-1:0] COND_CLASS = 6'h3A,
    parameter logic [CLS_W-1:0] COND_MASK  = 6'h3E,
    localparam int WORD_W = 2 * SLOT_W + 2,
    localparam int LONG_W = 2 * SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    input  logic              exec_ack,
    input  logic              exec_pc_chg,
    input  logic              exec_exc,
    input  logic              exec_cond,
    output logic              issue_valid,
    output logic [1:0]        issue_tag,
    output logic [LONG_W-1:0] issue_payload,
    output logic [CLS_W-1:0]  issue_class,
    output logic              issue_test,
    output logic              done,
    output logic              ev_cond_true,
    output logic              ev_cond_false,
    output logic              ev_branch_skip
);
    logic [WORD_W-1:0] word_q;
    logic              load;
    mode_e             mode;
    slot_tag_e         first_tag;
    slot_tag_e         second_tag;
    slot_tag_e         cur_tag;
    logic [2:0]        events;

    // Capture the fetched word when the sequencer accepts it.
    always_ff @(posedge clk) begin
        if (!rst_n)    word_q <= '0;
        else if (load) word_q <= word_in;
    end

    wd_decode #(
        .SLOT_W(SLOT_W), .CLS_W(CLS_W),
        .COND_CLASS(COND_CLASS), .COND_MASK(COND_MASK)
    ) u_decode (
        .word(word_q), .mode(mode),
        .first_tag(first_tag), .second_tag(second_tag)
    );

    wd_seq u_seq (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid),
        .exec_ack(exec_ack), .exec_pc_chg(exec_pc_chg),
        .exec_exc(exec_exc), .exec_cond(exec_cond),
        .mode(mode), .first_tag(first_tag), .second_tag(second_tag),
        .load(load), .issue_valid(issue_valid), .cur_tag(cur_tag),
        .issue_test(issue_test), .done(done), .events(events)
    );

    wd_select #(.SLOT_W(SLOT_W), .CLS_W(CLS_W)) u_select (
        .word(word_q), .tag(cur_tag),
        .payload(issue_payload), .cls(issue_class)
    );

    assign issue_tag      = cur_tag;
    assign ev_cond_true   = events[0];
    assign ev_cond_false  = events[1];
    assign ev_branch_skip = events[2];
endmodule

// File: rtl/wd_dispatch_chk.sv
// Module: wd_dispatch_chk
// Protocol checker for wd_dispatch, attached by bind. Observes ports only.
module wd_dispatch_chk #(
    parameter int SLOT_W = 15,
    parameter int CLS_W  = 6,
    localparam int LONG_W = 2 * SLOT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exec_ack,
    input logic              issue_valid,
    input logic [1:0]        issue_tag,
    input logic [LONG_W-1:0] issue_payload,
    input logic              issue_test,
    input logic              done,
    input logic              ev_cond_true,
    input logic              ev_cond_false,
    input logic              ev_branch_skip
);
    // R2: a long issue that is acknowledged finishes the word.
    a_r2_long_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && exec_ack && issue_tag == 2'b00 |=> done);

    // R9: an issue waiting for ack keeps its payload and tag.
    a_r9_issue_hold: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && !exec_ack |=> issue_valid && $stable(issue_payload) && $stable(issue_tag));

    // R9: done lasts one cycle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done never overlaps an issue.
    a_r9_done_alone: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !issue_valid);

    // R6: at most one outcome event, and only together with done.
    a_r6_event_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_cond_true, ev_cond_false, ev_branch_skip}));

    a_r6_event_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cond_true || ev_cond_false || ev_branch_skip) |-> done);

    // R6: the condition test is issued once, first, and only as an issue.
    a_r6_test_first: assert property (@(posedge clk) disable iff (!rst_n)
        issue_test && exec_ack |=> !issue_test);

    a_r6_test_is_issue: assert property (@(posedge clk) disable iff (!rst_n)
        issue_test |-> issue_valid);
endmodule

bind wd_dispatch wd_dispatch_chk #(.SLOT_W(SLOT_W), .CLS_W(CLS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .exec_ack(exec_ack),
    .issue_valid(issue_valid), .issue_tag(issue_tag),
    .issue_payload(issue_payload), .issue_test(issue_test), .done(done),
    .ev_cond_true(ev_cond_true), .ev_cond_false(ev_cond_false),
    .ev_branch_skip(ev_branch_skip)
);

// File: tb/wd_dispatch_tb.sv
// Scoreboard bench: the driver predicts the issue stream and outcome of each
// word, and the monitor compares them and answers each issue with an ack.
module wd_dispatch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [31:0] word_in = '0;
    logic        exec_ack = 1'b0, exec_pc_chg = 1'b0, exec_exc = 1'b0, exec_cond = 1'b0;
    logic        issue_valid, issue_test, done;
    logic [1:0]  issue_tag;
    logic [29:0] issue_payload;
    logic [5:0]  issue_class;
    logic        ev_cond_true, ev_cond_false, ev_branch_skip;

    always #2.5 clk = ~clk;

    wd_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
        .exec_ack(exec_ack), .exec_pc_chg(exec_pc_chg), .exec_exc(exec_exc),
        .exec_cond(exec_cond), .issue_valid(issue_valid), .issue_tag(issue_tag),
        .issue_payload(issue_payload), .issue_class(issue_class),
        .issue_test(issue_test), .done(done), .ev_cond_true(ev_cond_true),
        .ev_cond_false(ev_cond_false), .ev_branch_skip(ev_branch_skip)
    );

    typedef struct packed {
        logic [1:0]  tag;
        logic [29:0] pay;
        logic [5:0]  cls;
        logic        test;
    } item_t;

    item_t      expq[$];
    logic [2:0] evq[$];     // {branch, false, true}
    int n_chk = 0, n_err = 0, done_cnt = 0;
    logic [2:0] fb = 3'b000; // {pc, exc, cond} for the first ack
    int  ack_dly = 0;
    int  slot_idx = 0;
    string cur_req = "R1";
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R6: guard class rule with defaults 3A/3E.
    function automatic bit is_test(input logic [14:0] s);
        return (s[14:9] & 6'h3E) == 6'h3A;
    endfunction

    function automatic item_t mk(input logic [1:0] t, input logic [14:0] s, input bit tst);
        item_t it;
        it.tag = t; it.pay = {15'b0, s}; it.cls = s[14:9]; it.test = tst;
        return it;
    endfunction

    // Driver: predict, then present the word; optionally strobe again while busy.
    task automatic send(input logic [31:0] w, input bit pc, input bit exc, input bit cnd,
                        input int dly, input bit glitch, input string req);
        logic [14:0] l, r;
        logic [2:0]  ev;
        int tgt;
        l = w[29:15]; r = w[14:0]; ev = 3'b000;
        case (w[31:30])
            2'b11: begin
                item_t it;
                it.tag = 2'b00; it.pay = w[29:0]; it.cls = w[29:24]; it.test = 1'b0;
                expq.push_back(it);
            end
            2'b01: begin
                expq.push_back(mk(2'b01, l, 1'b0));
                if (!pc && !exc) expq.push_back(mk(2'b10, r, 1'b0));
                ev[2] = pc && !exc;
            end
            2'b10: begin
                expq.push_back(mk(2'b10, r, 1'b0));
                if (!pc && !exc) expq.push_back(mk(2'b01, l, 1'b0));
                ev[2] = pc && !exc;
            end
            default: begin
                if (is_test(l)) begin
                    expq.push_back(mk(2'b01, l, 1'b1));
                    if (cnd) expq.push_back(mk(2'b10, r, 1'b0));
                    ev[0] = cnd; ev[1] = !cnd;
                end else if (is_test(r)) begin
                    expq.push_back(mk(2'b10, r, 1'b1));
                    if (cnd) expq.push_back(mk(2'b01, l, 1'b0));
                    ev[0] = cnd; ev[1] = !cnd;
                end else begin
                    expq.push_back(mk(2'b01, l, 1'b0));
                    if (!exc) expq.push_back(mk(2'b10, r, 1'b0));
                end
            end
        endcase
        evq.push_back(ev);
        fb = {pc, exc, cnd}; ack_dly = dly; slot_idx = 0; cur_req = req;
        tgt = done_cnt + 1;
        @(negedge clk); word_valid = 1'b1; word_in = w;
        @(negedge clk); word_valid = 1'b0;
        if (glitch) begin
            @(negedge clk); word_valid = 1'b1; word_in = 32'hC0AB_CDEF;
            @(negedge clk); word_valid = 1'b0;
        end
        wait (done_cnt >= tgt || finished);
        @(negedge clk);
    endtask

    // Monitor: compare each new issue, check stability, ack, and score done.
    initial begin
        bit in_issue = 1'b0;
        int wcnt = 0;
        item_t hold;
        hold = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (done) begin
                    logic [2:0] act;
                    act = {ev_branch_skip, ev_cond_false, ev_cond_true};
                    chk(expq.size() == 0, "R9 missing issue before done", 64'(expq.size()), 64'd0);
                    if (evq.size() == 0) chk(1'b0, "R9 unexpected done", 64'd1, 64'd0);
                    else begin
                        logic [2:0] e;
                        e = evq.pop_front();
                        chk(act === e, {cur_req, " R5/R6 outcome events"}, 64'(act), 64'(e));
                    end
                    done_cnt++;
                end
                if (issue_valid && !in_issue) begin
                    if (expq.size() == 0) chk(1'b0, {cur_req, " R10 unexpected issue"}, 64'(issue_payload), 64'd0);
                    else begin
                        item_t e;
                        e = expq.pop_front();
                        chk(issue_tag === e.tag && issue_payload === e.pay && issue_test === e.test,
                            {cur_req, " issue tag/payload/test"},
                            {29'b0, issue_tag, issue_payload, issue_test}, {29'b0, e.tag, e.pay, e.test});
                        chk(issue_class === e.cls, "R8 issue class", 64'(issue_class), 64'(e.cls));
                    end
                    hold = {issue_tag, issue_payload, issue_class, issue_test};
                    in_issue = 1'b1; wcnt = 0;
                end else if (issue_valid) begin
                    chk({issue_tag, issue_payload} === {hold.tag, hold.pay}, "R9 issue held stable",
                        64'({issue_tag, issue_payload}), 64'({hold.tag, hold.pay}));
                end
                if (issue_valid && wcnt == ack_dly) begin
                    exec_ack = 1'b1;
                    {exec_pc_chg, exec_exc, exec_cond} = (slot_idx == 0) ? fb : 3'b000;
                    slot_idx++; in_issue = 1'b0;
                end else begin
                    exec_ack = 1'b0;
                    {exec_pc_chg, exec_exc, exec_cond} = 3'b000;
                    if (issue_valid) wcnt++;
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({issue_valid, issue_test, done, ev_cond_true, ev_cond_false, ev_branch_skip} === 6'b0,
            "R1 reset outputs", 64'({issue_valid, issue_test, done}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({issue_valid, done} === 2'b00, "R1 idle after reset", 64'({issue_valid, done}), 64'd0);

        send(32'hF5A3_1234, 0, 0, 0, 0, 0, "R2");                                     // long, immediate ack
        send({2'b01, 15'h1234, 15'h0567}, 0, 0, 0, 2, 0, "R3");                        // left then right
        send({2'b10, 15'h1234, 15'h0567}, 0, 0, 0, 1, 0, "R4");                        // right then left
        send({2'b01, 15'h2A11, 15'h4C02}, 1, 0, 0, 0, 0, "R5");                        // branch skip
        send({2'b10, 15'h2A11, 15'h4C02}, 0, 1, 0, 1, 0, "R5");                        // exception, no event
        send({2'b01, 15'h2A11, 15'h4C02}, 1, 1, 0, 0, 0, "R5");                        // both, no event
        send({2'b00, 15'h1234, 15'h0567}, 0, 1, 0, 0, 0, "R7");                        // par, exception drops right
        send({2'b00, 15'h1234, 15'h0567}, 1, 0, 0, 1, 0, "R7");                        // par, pc change ignored
        send({2'b00, 15'h7415, 15'h0567}, 0, 0, 1, 0, 0, "R6");                        // left test true
        send({2'b00, 15'h1234, 15'h7603}, 0, 0, 0, 2, 0, "R6");                        // right test false
        send({2'b00, 15'h7401, 15'h7602}, 0, 0, 1, 0, 0, "R6");                        // both tests: left first
        send({2'b00, 15'h0BCD, 15'h7410}, 0, 0, 1, 1, 0, "R6");                        // right test true
        send({2'b01, 15'h1111, 15'h2222}, 0, 0, 0, 3, 1, "R10");                       // strobe while busy
        repeat (3) begin
            @(negedge clk);
            chk(issue_valid === 1'b0, "R10 no issue after busy strobe", 64'(issue_valid), 64'd0);
        end
        send(32'hC000_0001, 0, 0, 0, 4, 1, "R10");                                     // long, strobe while busy
        repeat (3) begin
            @(negedge clk);
            chk(issue_valid === 1'b0 && done === 1'b0, "R10 idle after word",
                64'({issue_valid, done}), 64'd0);
        end
        chk(expq.size() == 0 && evq.size() == 0, "R9 scoreboard drained",
            64'(expq.size() + evq.size()), 64'd0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule